// File: doc/BRIEF.md
# Buffered Bidirectional Data Path

This block sits between a fast bus on port A and a slower memory or peripheral on port B. Traffic heading from A to B goes through a small queue of four words. The fast side can post several writes back to back, and the slow side drains them at its own pace. One clock runs the queue. A low-active enable pushes a word and a second low-active enable pops one. A registered, low-active flag reports when no slot is free.

Traffic heading from B to A goes through a single level-sensitive holding latch. While its enable is high, B data flows straight through to A. When the enable falls, the last value is kept. Each direction has its own low-active output enable. The block exports each one as a drive-enable signal for the pad ring instead of driving a tri-state pin itself. A synchronous reset empties the queue and forces the queue output to all ones.

Top module: `rw_buffer`

## Requirements
- R1: Words pushed with `wr_en_n` low are presented on `b_out` in push order. `b_out` takes a new word on the rising edge at which `rd_en_n` is low and the queue is not empty.
- R2: `full_n` is low exactly while four words are stored. It goes low on the edge that stores the fourth word. It returns high on the edge that removes a word.
- R3: A push attempted while four words are stored is discarded. The stored words and their order are unchanged.
- R4: A pop attempted while the queue is empty has no effect. `b_out` keeps the last word popped.
- R5: A push and a pop in the same cycle both take effect when 1 to 3 words are stored. When the queue is empty, only the push is performed. When it is full, only the pop is performed.
- R6: `rst` is synchronous and active high. The edge that samples it high empties the queue, sets `b_out` to all ones and sets `full_n` high.
- R7: `b_out` changes only on an accepted pop or on reset. After reset it reads all ones until the first accepted pop.
- R8: While `latch_en` is high, `a_out` follows `b_in` with no clock involved.
- R9: While `latch_en` is low, `a_out` holds the value `b_in` had when `latch_en` fell.
- R10: `b_drive` is high exactly when `b_oe_n` is low. `a_drive` is high exactly when `a_oe_n` is low.
- R11: The queue and the latch operate independently. Latch activity does not alter queue contents or flags, and queue activity does not alter `a_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Queue clock |
| rst | input | 1 | Synchronous active-high queue reset |
| a_in | input | 18 | Write data arriving from the fast bus |
| wr_en_n | input | 1 | Push enable, active low |
| rd_en_n | input | 1 | Pop enable, active low |
| full_n | output | 1 | Queue full, active low, registered |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_out | output | 18 | Queue output toward port B |
| b_drive | output | 1 | Port B pad drive enable, active high |
| b_in | input | 18 | Read data arriving from port B |
| latch_en | input | 1 | Holding latch enable, transparent when high |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_out | output | 18 | Latch output toward port A |
| a_drive | output | 1 | Port A pad drive enable, active high |

## Verification
The checker examines several properties on every clock. Occupancy never goes past four. A push with no pop while full leaves occupancy unchanged. A pop while full releases the full flag. `b_out` holds still whenever no pop is requested or the queue is empty. Reset release finds the queue empty, the output all ones and the flag high. Some behaviour depends on which data words were kept, so only the directed scenarios can show it: push order, a dropped word never appearing, which operation wins at each boundary, and the latch following and holding while the queue runs.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int RWB_WIDTH = 18;
  localparam int RWB_DEPTH = 4;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } rwb_op_e;
endpackage

// File: rtl/rwb_ctrl.sv
module rwb_ctrl import rwb_pkg::*; #(
  parameter int DEPTH = RWB_DEPTH,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [CW-1:0] occ,
  output logic          full_n
);
  logic [CW-1:0] occ_nx;
  rwb_op_e       op;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // Boundaries resolve naturally: pop blocked when empty, push blocked when full
  assign push_ok = push_req && (occ != CW'(DEPTH));
  assign pop_ok  = pop_req  && (occ != '0);
  assign op      = rwb_op_e'({pop_ok, push_ok});

  always_comb begin
    unique case (op)
      OP_PUSH: occ_nx = occ + CW'(1);
      OP_POP:  occ_nx = occ - CW'(1);
      default: occ_nx = occ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      occ    <= '0;
      full_n <= 1'b1;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      occ    <= occ_nx;
      full_n <= (occ_nx != CW'(DEPTH));
    end
  end
endmodule

// File: rtl/rwb_store.sv
module rwb_store #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] wptr,
  input  logic [W-1:0]  din,
  input  logic          re,
  input  logic [PW-1:0] rptr,
  output logic [W-1:0]  dout
);
  logic [W-1:0] mem [DEPTH];

  // Storage array carries no reset so it maps onto RAM resources
  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)     dout <= '1;
    else if (re) dout <= mem[rptr];
  end
endmodule

// File: rtl/rwb_hold_latch.sv
module rwb_hold_latch #(
  parameter int W = 18
) (
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (le) q = d;
  end
endmodule

// File: rtl/rw_buffer.sv
module rw_buffer import rwb_pkg::*; #(
  parameter int W     = RWB_WIDTH,
  parameter int DEPTH = RWB_DEPTH,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         wr_en_n,
  input  logic         rd_en_n,
  output logic         full_n,
  input  logic         b_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic [W-1:0] b_in,
  input  logic         latch_en,
  input  logic         a_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  logic          push_ok, pop_ok;
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] occ;

  rwb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst),
    .push_req(!wr_en_n), .pop_req(!rd_en_n),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wptr(wptr), .rptr(rptr), .occ(occ), .full_n(full_n)
  );

  rwb_store #(.W(W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst),
    .we(push_ok), .wptr(wptr), .din(a_in),
    .re(pop_ok), .rptr(rptr), .dout(b_out)
  );

  rwb_hold_latch #(.W(W)) latch_i (
    .le(latch_en), .d(b_in), .q(a_out)
  );

  assign b_drive = !b_oe_n;
  assign a_drive = !a_oe_n;
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          full_n,
  input logic [W-1:0]  b_out,
  input logic [CW-1:0] occ
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !wr_en_n && rd_en_n) |=> (occ == CW'(DEPTH)) && !full_n);

  assert_full_release_R2: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !rd_en_n) |=> full_n);

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |=> $stable(b_out));

  assert_out_stable_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en_n |=> $stable(b_out));

  assert_reset_state_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (b_out == '1) && full_n && (occ == '0));
endmodule

bind rw_buffer rwb_checker #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .full_n(full_n), .b_out(b_out), .occ(occ)
);

// File: tb/rw_buffer_tb_top.sv
module rw_buffer_tb_top;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic         wr_en_n = 1'b1;
  logic         rd_en_n = 1'b1;
  logic         full_n;
  logic         b_oe_n = 1'b0;
  logic [W-1:0] b_out;
  logic         b_drive;
  logic [W-1:0] b_in = '0;
  logic         latch_en = 1'b0;
  logic         a_oe_n = 1'b0;
  logic [W-1:0] a_out;
  logic         a_drive;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  rw_buffer dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .full_n(full_n), .b_oe_n(b_oe_n), .b_out(b_out), .b_drive(b_drive),
    .b_in(b_in), .latch_en(latch_en), .a_oe_n(a_oe_n), .a_out(a_out),
    .a_drive(a_drive)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with the given enables; inputs change 1 ns after the edge
  task automatic cyc(input bit push, input bit pop, input logic [W-1:0] d);
    wr_en_n = !push;
    rd_en_n = !pop;
    a_in    = d;
    @(posedge clk); #1;
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R6 b_out ones", b_out, ONES);
    chk("R6 full_n high", W'(full_n), W'(1));
    cyc(0, 0, '0);
    chk("R7 idle after reset", b_out, ONES);
  endtask

  task automatic t_fill_order();
    logic [W-1:0] w [4] = '{18'h0A5A5, 18'h15A5A, 18'h00F0F, 18'h3C3C3};
    for (int i = 0; i < 4; i++) begin
      chk("R2 not full yet", W'(full_n), W'(1));
      cyc(1, 0, w[i]);
    end
    chk("R2 full after four", W'(full_n), W'(0));
    cyc(1, 0, 18'h2DEAD);
    chk("R3 still full", W'(full_n), W'(0));
    chk("R7 no pop no change", b_out, ONES);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 1, '0);
      chk("R1 order", b_out, w[i]);
      chk("R2 flag released", W'(full_n), W'(1));
      cyc(0, 0, '0);
      chk("R7 stable between pops", b_out, w[i]);
    end
    cyc(0, 1, '0);
    chk("R3 R4 empty pop holds, dropped word absent", b_out, w[3]);
  endtask

  task automatic t_both_empty();
    cyc(1, 1, 18'h12345);
    chk("R5 empty: pop ignored", b_out, 18'h3C3C3);
    cyc(0, 1, '0);
    chk("R5 empty: push kept", b_out, 18'h12345);
    cyc(0, 1, '0);
    chk("R4 empty again", b_out, 18'h12345);
  endtask

  task automatic t_both_mid();
    cyc(1, 0, 18'h00011);
    cyc(1, 0, 18'h00022);
    cyc(1, 1, 18'h00033);
    chk("R5 mid: pop done", b_out, 18'h00011);
    chk("R5 mid: not full", W'(full_n), W'(1));
    cyc(0, 1, '0);
    chk("R5 mid: second", b_out, 18'h00022);
    cyc(0, 1, '0);
    chk("R5 mid: push done", b_out, 18'h00033);
    cyc(0, 1, '0);
    chk("R4 drained", b_out, 18'h00033);
  endtask

  task automatic t_both_full();
    for (int i = 0; i < 4; i++) cyc(1, 0, W'(18'h20000 + i));
    chk("R2 full", W'(full_n), W'(0));
    cyc(1, 1, 18'h3FF00);
    chk("R5 full: pop done", b_out, 18'h20000);
    chk("R5 full: push dropped, flag high", W'(full_n), W'(1));
    for (int i = 1; i < 4; i++) begin
      cyc(0, 1, '0);
      chk("R5 full: remaining order", b_out, W'(18'h20000 + i));
    end
    cyc(0, 1, '0);
    chk("R5 full: dropped word absent", b_out, 18'h20003);
  endtask

  task automatic t_reset_mid();
    cyc(1, 0, 18'h0ABCD);
    cyc(1, 0, 18'h0BCDE);
    do_reset();
    chk("R6 ones after mid reset", b_out, ONES);
    chk("R6 flag high", W'(full_n), W'(1));
    cyc(0, 1, '0);
    chk("R6 emptied", b_out, ONES);
  endtask

  task automatic t_latch_indep();
    latch_en = 1'b1; b_in = 18'h1F0F0; #1;
    chk("R8 transparent", a_out, 18'h1F0F0);
    b_in = 18'h0AAAA; #1;
    chk("R8 follows", a_out, 18'h0AAAA);
    cyc(1, 0, 18'h01111);
    latch_en = 1'b0; #1;
    b_in = 18'h35555; #1;
    chk("R9 holds", a_out, 18'h0AAAA);
    cyc(1, 0, 18'h02222);
    chk("R11 latch unaffected by queue", a_out, 18'h0AAAA);
    latch_en = 1'b1; #1; latch_en = 1'b0; b_in = 18'h00007;
    cyc(0, 1, '0);
    chk("R11 queue unaffected by latch", b_out, 18'h01111);
    cyc(0, 1, '0);
    chk("R11 second word", b_out, 18'h02222);
    chk("R9 recaptured", a_out, 18'h35555);
  endtask

  task automatic t_drive();
    b_oe_n = 1'b0; a_oe_n = 1'b1; #1;
    chk("R10 b_drive on", W'(b_drive), W'(1));
    chk("R10 a_drive off", W'(a_drive), W'(0));
    b_oe_n = 1'b1; a_oe_n = 1'b0; #1;
    chk("R10 b_drive off", W'(b_drive), W'(0));
    chk("R10 a_drive on", W'(a_drive), W'(1));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_fill_order();
    t_both_empty();
    t_both_mid();
    t_both_full();
    t_reset_mid();
    t_latch_indep();
    t_drive();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule